// File: doc/BRIEF.md
# Peripheral Interrupt Pending Tracker

This block keeps the pending state of a bank of peripheral interrupt lines for one processor. Every line passes through a synchroniser. The block then compares the synchronised value with the level it stored on the previous clock. A per-line trigger-mode bit chooses how a line is handled:

- **Edge-triggered lines:** a low-to-high change sets a sticky pending latch.
- **Level-triggered lines:** the line reports pending for as long as its input is high.

A register interface can also set or clear the sticky latch through one-cycle bitmap pulses. It can also rewrite the trigger-mode bits.

The pending vector seen by the priority logic is the latch ORed with the live level of the level-triggered lines. Clearing the latch therefore cannot remove a level line whose input is still asserted. A falling input never clears anything. It only updates the stored level.

Top module: `irq_pend_tracker`

## Requirements
- R1: After reset, `pend_o`, `level_o` and `edge_cfg_o` are all zero.
- R2: A change on `irq_in[i]` that is present before rising clock edge k appears on `level_o[i]` right after edge k+2, and not earlier. Two synchroniser flops precede the stored level. An input that keeps its stored value causes no change.
- R3: A low-to-high change of the stored level on a line whose `edge_cfg_o` bit is 1 sets that line's pending latch. The latch is set on the same edge that updates `level_o`.
- R4: A high-to-low change of the stored level leaves the pending latch unchanged.
- R5: For a line whose `edge_cfg_o` bit is 0, `pend_o` follows `level_o`. A rising input on such a line does not set the latch, so the line stops pending once its input falls.
- R6: A 1 in `set_mask` sets the latch of that line on the next rising edge. This holds whatever the input level or trigger mode of the line.
- R7: A 1 in `clr_mask` clears only the latch of that line. A level-triggered line whose input is still high stays pending.
- R8: When a rising edge on an edge-triggered line and a clear of the same line fall in the same cycle, the edge wins and the latch ends up set.
- R9: When `set_mask` and `clr_mask` select the same line in the same cycle, the set wins.
- R10: A cycle with `edge_cfg_we` high loads `edge_cfg_wdata` into `edge_cfg_o` on the next edge. A bit value of 1 selects edge mode. The new mode governs later input changes. Rewriting the mode does not change any pending latch.
- R11: At all times, for every line, `pend_o` equals its latch ORed with (`level_o` AND NOT `edge_cfg_o`). Lines are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Asynchronous interrupt input lines |
| edge_cfg_we | input | 1 | Write strobe for the trigger-mode bits |
| edge_cfg_wdata | input | NUM_LINES | New trigger-mode bits (1 = edge, 0 = level) |
| set_mask | input | NUM_LINES | One-cycle set-pending bitmap |
| clr_mask | input | NUM_LINES | One-cycle clear-pending bitmap |
| pend_o | output | NUM_LINES | Effective pending vector |
| level_o | output | NUM_LINES | Stored, synchronised input level |
| edge_cfg_o | output | NUM_LINES | Current trigger-mode bits |

## Verification
Two pairs of events can land on one line's latch in the same cycle: a detected rising edge with a software clear, and a software set with a software clear. For the first pair, the bench raises an edge-mode input and counts two falling clock edges. It then places a one-cycle clear pulse in exactly the cycle where the synchronised rise is compared against the stored level. The pending bit must still read 1 afterwards. For the second pair, both masks are pulsed for one line together and the bit must read 1. A later lone clear must drop it, which shows that the clear path itself works.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  // Next value of one pending latch: a hardware edge hit or a software set
  // always wins over a software clear.
  function automatic logic f_latch_next(input logic cur, input logic sw_set,
                                        input logic sw_clr, input logic hw_hit);
    return hw_hit | sw_set | (cur & ~sw_clr);
  endfunction

  // Effective pending for one line.
  function automatic logic f_eff_pend(input logic latch, input logic lvl,
                                      input logic is_edge);
    return latch | (lvl & ~is_edge);
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[LAST];
endmodule

// File: rtl/irq_edge_cfg.sv
module irq_edge_cfg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] cfg_o
);
  logic [WIDTH-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign cfg_o = cfg_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(cfg_q)); // R10
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (cfg_q == $past(wdata_i))); // R10
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_pend_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_lvl_i,
  input  logic is_edge_i,
  input  logic set_i,
  input  logic clr_i,
  output logic lvl_o,
  output logic latch_o,
  output logic pend_o
);
  logic lvl_q;
  logic latch_q;

  // Named events for the checks below.
  logic rise;
  logic fall;
  logic edge_hit;

  assign rise     = sync_lvl_i & ~lvl_q;
  assign fall     = ~sync_lvl_i & lvl_q;
  assign edge_hit = rise & is_edge_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      lvl_q   <= sync_lvl_i;
      latch_q <= f_latch_next(latch_q, set_i, clr_i, edge_hit);
    end
  end

  assign lvl_o   = lvl_q;
  assign latch_o = latch_q;
  assign pend_o  = f_eff_pend(latch_q, lvl_q, is_edge_i);

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && is_edge_i) |=> latch_q); // R3
  AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && is_edge_i && clr_i) |=> latch_q); // R8
  AST_FALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && latch_q && !clr_i) |=> latch_q); // R4
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !is_edge_i && !set_i && !latch_q) |=> !latch_q); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> latch_q); // R9
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i && !edge_hit) |=> !latch_q); // R7
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker #(
  parameter int NUM_LINES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 edge_cfg_we,
  input  logic [NUM_LINES-1:0] edge_cfg_wdata,
  input  logic [NUM_LINES-1:0] set_mask,
  input  logic [NUM_LINES-1:0] clr_mask,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] level_o,
  output logic [NUM_LINES-1:0] edge_cfg_o
);
  logic [NUM_LINES-1:0] irq_sync;
  logic [NUM_LINES-1:0] cfg_q;
  logic [NUM_LINES-1:0] latch_vec;

  irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (irq_in),
    .sync_o  (irq_sync)
  );

  irq_edge_cfg #(.WIDTH(NUM_LINES)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (edge_cfg_we),
    .wdata_i (edge_cfg_wdata),
    .cfg_o   (cfg_q)
  );

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      irq_line_cell u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_lvl_i (irq_sync[i]),
        .is_edge_i  (cfg_q[i]),
        .set_i      (set_mask[i]),
        .clr_i      (clr_mask[i]),
        .lvl_o      (level_o[i]),
        .latch_o    (latch_vec[i]),
        .pend_o     (pend_o[i])
      );
    end
  endgenerate

  assign edge_cfg_o = cfg_q;

  AST_LEVEL_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((level_o & ~edge_cfg_o & ~pend_o) == '0)); // R11
  AST_PEND_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o & ~latch_vec & ~(level_o & ~edge_cfg_o)) == '0)); // R11
endmodule

// File: tb/irq_pend_tracker_tb.sv
`timescale 1ns/1ps
module irq_pend_tracker_tb;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] irq_in;
  logic         edge_cfg_we;
  logic [N-1:0] edge_cfg_wdata;
  logic [N-1:0] set_mask;
  logic [N-1:0] clr_mask;
  logic [N-1:0] pend_o;
  logic [N-1:0] level_o;
  logic [N-1:0] edge_cfg_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_pend_tracker #(.NUM_LINES(N), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .edge_cfg_we(edge_cfg_we), .edge_cfg_wdata(edge_cfg_wdata),
    .set_mask(set_mask), .clr_mask(clr_mask),
    .pend_o(pend_o), .level_o(level_o), .edge_cfg_o(edge_cfg_o)
  );

  // kind: 0 = pend_o, 1 = level_o, 2 = edge_cfg_o
  typedef struct {
    int           kind;
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  item_t sb[$];

  task automatic push(input int kind, input logic [N-1:0] exp, input string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    sb.push_back(it);
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_set(input logic [N-1:0] m);
    set_mask = m; @(negedge clk); set_mask = '0;
  endtask

  task automatic pulse_clr(input logic [N-1:0] m);
    clr_mask = m; @(negedge clk); clr_mask = '0;
  endtask

  task automatic write_cfg(input logic [N-1:0] v);
    edge_cfg_we = 1'b1; edge_cfg_wdata = v;
    @(negedge clk);
    edge_cfg_we = 1'b0; edge_cfg_wdata = '0;
  endtask

  // Monitor: compares queued expectations shortly after each falling edge.
  initial begin
    item_t it;
    logic [N-1:0] act;
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        it = sb.pop_front();
        case (it.kind)
          0:       act = pend_o;
          1:       act = level_o;
          default: act = edge_cfg_o;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; edge_cfg_we = 1'b0; edge_cfg_wdata = '0;
    set_mask = '0; clr_mask = '0;
    wait_neg(3);
    rst_n = 1'b1;
    push(0, 16'h0000, "R1 pend after reset");
    push(1, 16'h0000, "R1 level after reset");
    push(2, 16'h0000, "R1 edge cfg after reset");
    wait_neg(1);

    write_cfg(16'h00FF);
    push(2, 16'h00FF, "R10 cfg load");

    // R2 / R3: rising input on an edge line
    irq_in = 16'h0001;
    wait_neg(2);
    push(1, 16'h0000, "R2 level not yet visible");
    wait_neg(1);
    push(1, 16'h0001, "R2 level after two sync flops");
    push(0, 16'h0001, "R3 edge latched");

    // R4: falling input keeps latch
    irq_in = 16'h0000;
    wait_neg(3);
    push(1, 16'h0000, "R4 level fell");
    push(0, 16'h0001, "R4 pend kept after fall");

    pulse_clr(16'h0001);
    push(0, 16'h0000, "R7 clear edge latch");

    // R5: level line follows input
    irq_in = 16'h0100;
    wait_neg(3);
    push(0, 16'h0100, "R5 level line pending");
    irq_in = 16'h0000;
    wait_neg(3);
    push(0, 16'h0000, "R5 level line no latch");

    // R7: clear cannot drop a still-asserted level line
    irq_in = 16'h0100;
    wait_neg(3);
    pulse_set(16'h0100);
    pulse_clr(16'h0100);
    push(0, 16'h0100, "R7 level line survives clear");
    irq_in = 16'h0000;
    wait_neg(3);
    push(0, 16'h0000, "R7 latch was cleared");

    // R6: software set
    pulse_set(16'h1000);
    push(0, 16'h1000, "R6 set on idle level line");
    wait_neg(3);
    push(0, 16'h1000, "R6 set is sticky");

    // R9: set and clear together
    set_mask = 16'h0008; clr_mask = 16'h0008;
    @(negedge clk);
    set_mask = '0; clr_mask = '0;
    push(0, 16'h1008, "R9 set beats clear");
    pulse_clr(16'h0008);
    push(0, 16'h1000, "R9 lone clear works");

    // R8: edge and clear in the same cycle
    irq_in = 16'h0002;
    wait_neg(2);
    clr_mask = 16'h0002;
    @(negedge clk);
    clr_mask = '0;
    push(0, 16'h1002, "R8 edge beats clear");
    irq_in = 16'h0000;
    wait_neg(3);
    pulse_clr(16'h0002);
    push(0, 16'h1000, "R8 later clear works");

    // R10: reconfiguration
    write_cfg(16'h11FF);
    push(2, 16'h11FF, "R10 cfg reload");
    push(0, 16'h1000, "R10 reconfig keeps latch");
    irq_in = 16'h0100;
    wait_neg(3);
    push(0, 16'h1100, "R10 new edge line latches");
    irq_in = 16'h0000;
    wait_neg(3);
    push(0, 16'h1100, "R10 new edge line sticky");

    // R11: several lines at once
    pulse_clr(16'hFFFF);
    push(0, 16'h0000, "R11 all cleared");
    write_cfg(16'h00FF);
    irq_in = 16'h3C3C;
    wait_neg(3);
    push(0, 16'h3C3C, "R11 mixed pattern high");
    push(1, 16'h3C3C, "R11 mixed levels");
    irq_in = 16'h0000;
    wait_neg(3);
    push(0, 16'h003C, "R11 mixed pattern low");

    wait_neg(3);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual=%0d expected=0 pending items", sb.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule